// File: doc/BRIEF.md
# Transmit Timestamp Capture Slots

This block holds a small set of independent capture slots for transmit timestamps. The host arms a slot by naming it on the request input. An armed slot waits for the next transmitted packet to finish. When the packet completes and its transmit trigger was seen, the current time value is latched into every armed slot. When the packet completes without a trigger, each armed slot reports a missed capture instead. In both cases the arming is then cleared.

Each slot keeps an unread flag. A capture sets the flag, and a host read of that slot clears it. If a capture lands in a slot whose earlier value was never read, the new time replaces the old one, so the old value is lost, and the slot reports an overflow. The missed and overflow indications are single-cycle pulses. A downstream status aggregator latches them into the vendor status word, which can raise the interrupt. The time counter and the packet parsing sit outside this block.

Top module: `txts_capture_slots`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `slot_valid`, `missed_pulse`, `ovf_pulse` and `rd_data` are all zero, and no slot is armed.
- R2: A slot armed by `req_valid` with `req_slot`=i captures the value of `time_in` at the edge where `pkt_done`=1 and `pkt_trig`=1. After that edge `slot_valid[i]` is 1.
- R3: An armed slot i that sees `pkt_done`=1 with `pkt_trig`=0 gives `missed_pulse[i]`=1 for the cycle after that edge. It captures nothing and is no longer armed, so a later triggered packet does not capture into it.
- R4: A capture into slot i while `slot_valid[i]` is already 1, with no read of slot i in the same cycle, gives `ovf_pulse[i]`=1 for one cycle. The new time replaces the stored value.
- R5: `rd_en`=1 with `rd_slot`=i (i < NUM_SLOTS) loads the stored value of slot i onto `rd_data` after that edge and clears `slot_valid[i]`. `rd_data` otherwise holds its value, including for a `rd_slot` out of range.
- R6: When a read of slot i and a capture into slot i happen in the same cycle, `rd_data` returns the old value and the new value is stored. `slot_valid[i]` stays 1 and `ovf_pulse[i]` stays 0.
- R7: `pkt_done` with no armed slot leaves `slot_valid`, the stored values, `missed_pulse` and `ovf_pulse` unchanged.
- R8: A request whose `req_slot` is NUM_SLOTS or larger is ignored. With 3 slots, index 3 arms nothing.
- R9: A request in the same cycle as `pkt_done` arms the slot for the next packet and is not resolved by the packet completing in that cycle.
- R10: `missed_pulse[i]` and `ovf_pulse[i]` fall back to 0 in the following cycle unless a new event occurs. The two are never 1 together for one slot.
- R11: Slots are independent. One `pkt_done` resolves every armed slot at the same time, and each slot keeps its own value, flag and pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Arm request strobe |
| req_slot | input | IDX_W | Slot to arm |
| pkt_done | input | 1 | Transmitted packet completed this cycle |
| pkt_trig | input | 1 | Transmit trigger was seen for the completing packet |
| time_in | input | TS_W | Current time value |
| rd_en | input | 1 | Host read strobe |
| rd_slot | input | IDX_W | Slot to read |
| rd_data | output | TS_W | Registered read value |
| slot_valid | output | NUM_SLOTS | Unread flag per slot |
| missed_pulse | output | NUM_SLOTS | One-cycle missed-capture pulse per slot |
| ovf_pulse | output | NUM_SLOTS | One-cycle overwrite pulse per slot |

## Verification
The bench builds the block with its defaults: three slots and 64-bit time. The 2-bit index then has one unused code, 3, so the out-of-range request and read paths of R8 and R5 can be reached. Random 64-bit time values exercise every bit of the stored words. Directed sequences cover the simultaneous read-and-capture case, the request arriving in the same cycle as packet completion, and several slots resolving at once. Long random runs with frequent reads and packets produce overflow and missed pulses on all three slots.

// File: rtl/txts_pkg.sv
package txts_pkg;
  // per-slot event outputs
  typedef struct packed {
    logic missed;
    logic ovf;
  } slot_evt_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/txts_decode.sv
module txts_decode #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     hit
);
  // index values at or above N match no slot
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/txts_slot.sv
module txts_slot
  import txts_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_hit,
  input  logic            pkt_done,
  input  logic            pkt_trig,
  input  logic            rd_hit,
  input  logic [TS_W-1:0] time_in,
  output logic [TS_W-1:0] ts_q,
  output logic            valid_q,
  output slot_evt_t       evt_q
);
  logic armed_q;
  logic take;
  logic lost;

  assign take = pkt_done && armed_q && pkt_trig;
  assign lost = pkt_done && armed_q && !pkt_trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      ts_q    <= '0;
      valid_q <= 1'b0;
      evt_q   <= '0;
    end else begin
      // a completing packet resolves the old arming; a new request arms for the next one
      armed_q    <= (armed_q && !pkt_done) || req_hit;
      if (take) ts_q <= time_in;
      valid_q    <= take || (valid_q && !rd_hit);
      evt_q.missed <= lost;
      evt_q.ovf    <= take && valid_q && !rd_hit;
    end
  end
endmodule

// File: rtl/txts_read_port.sv
module txts_read_port #(
  parameter int N     = 3,
  parameter int TS_W  = 64,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_slot,
  input  logic [N*TS_W-1:0] slot_data,
  output logic [TS_W-1:0]   rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rd_en && rd_slot == IDX_W'(i)) rd_data <= slot_data[i*TS_W +: TS_W];
      end
    end
  end
endmodule

// File: rtl/txts_capture_slots.sv
module txts_capture_slots
  import txts_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int TS_W      = 64,
  localparam int IDX_W    = idx_width(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_slot,
  input  logic                 pkt_done,
  input  logic                 pkt_trig,
  input  logic [TS_W-1:0]      time_in,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_slot,
  output logic [TS_W-1:0]      rd_data,
  output logic [NUM_SLOTS-1:0] slot_valid,
  output logic [NUM_SLOTS-1:0] missed_pulse,
  output logic [NUM_SLOTS-1:0] ovf_pulse
);
  logic [NUM_SLOTS-1:0]      req_hit;
  logic [NUM_SLOTS-1:0]      rd_hit;
  logic [NUM_SLOTS*TS_W-1:0] slot_data;

  txts_decode #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_req_dec (
    .en(req_valid), .idx(req_slot), .hit(req_hit)
  );

  txts_decode #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_rd_dec (
    .en(rd_en), .idx(rd_slot), .hit(rd_hit)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_evt_t evt;
    txts_slot #(.TS_W(TS_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .req_hit  (req_hit[i]),
      .pkt_done (pkt_done),
      .pkt_trig (pkt_trig),
      .rd_hit   (rd_hit[i]),
      .time_in  (time_in),
      .ts_q     (slot_data[i*TS_W +: TS_W]),
      .valid_q  (slot_valid[i]),
      .evt_q    (evt)
    );
    assign missed_pulse[i] = evt.missed;
    assign ovf_pulse[i]    = evt.ovf;
  end

  txts_read_port #(.N(NUM_SLOTS), .TS_W(TS_W), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_slot   (rd_slot),
    .slot_data (slot_data),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/txts_capture_slots_chk.sv
module txts_capture_slots_chk
  import txts_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int TS_W      = 64,
  localparam int IDX_W    = idx_width(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [IDX_W-1:0]     req_slot,
  input logic                 pkt_done,
  input logic                 pkt_trig,
  input logic [TS_W-1:0]      time_in,
  input logic                 rd_en,
  input logic [IDX_W-1:0]     rd_slot,
  input logic [TS_W-1:0]      rd_data,
  input logic [NUM_SLOTS-1:0] slot_valid,
  input logic [NUM_SLOTS-1:0] missed_pulse,
  input logic [NUM_SLOTS-1:0] ovf_pulse
);
  // R3: a missed pulse needs an untriggered packet completion in the cycle before
  a_r3_missed_needs_untriggered: assert property (@(posedge clk) disable iff (rst)
    (|missed_pulse) |-> $past(pkt_done && !pkt_trig));

  // R7: unread flags move only on packet completion or a read
  a_r7_valid_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!pkt_done && !rd_en) |-> (slot_valid == $past(slot_valid)));

  // R10: never a missed and an overflow pulse together for one slot
  a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((missed_pulse & ovf_pulse) == '0));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    // R4: overflow only on a slot that held an unread value
    a_r4_ovf_needs_unread: assert property (@(posedge clk) disable iff (rst)
      ovf_pulse[i] |-> $past(slot_valid[i]));

    // R2: a slot turns valid only after a triggered completion
    a_r2_valid_from_trigger: assert property (@(posedge clk) disable iff (rst)
      $rose(slot_valid[i]) |-> $past(pkt_done && pkt_trig));

    // R5: a read with no packet completing clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rd_en && rd_slot == IDX_W'(i) && !pkt_done) |-> !slot_valid[i]);

    // R6: a read of the slot in the same cycle suppresses overflow
    a_r6_no_ovf_on_read: assert property (@(posedge clk) disable iff (rst)
      $past(rd_en && rd_slot == IDX_W'(i)) |-> !ovf_pulse[i]);
  end
endmodule

bind txts_capture_slots txts_capture_slots_chk #(
  .NUM_SLOTS(NUM_SLOTS), .TS_W(TS_W)
) u_chk (.*);

// File: tb/txts_capture_slots_test.sv
module txts_capture_slots_test;
  localparam int N  = 3;
  localparam int W  = 64;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          req_valid;
  logic [IW-1:0] req_slot;
  logic          pkt_done;
  logic          pkt_trig;
  logic [W-1:0]  time_in;
  logic          rd_en;
  logic [IW-1:0] rd_slot;
  logic [W-1:0]  rd_data;
  logic [N-1:0]  slot_valid;
  logic [N-1:0]  missed_pulse;
  logic [N-1:0]  ovf_pulse;

  txts_capture_slots #(.NUM_SLOTS(N), .TS_W(W)) uut (.*);

  int checks = 0;
  int errors = 0;

  // expected state derived from the requirements
  logic         m_arm   [N];
  logic         m_val   [N];
  logic [W-1:0] m_store [N];
  logic [W-1:0] m_rd;
  logic [N-1:0] m_miss;
  logic [N-1:0] m_ovf;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_arm[i] = 0; m_val[i] = 0; m_store[i] = '0;
    end
    m_rd = '0; m_miss = '0; m_ovf = '0;
  endtask

  task automatic model_step();
    logic [W-1:0] old [N];
    for (int i = 0; i < N; i++) old[i] = m_store[i];
    for (int i = 0; i < N; i++) begin
      bit req_i = req_valid && (int'(req_slot) == i);
      bit rd_i  = rd_en && (int'(rd_slot) == i);
      bit cap   = pkt_done && m_arm[i] && pkt_trig;
      bit miss  = pkt_done && m_arm[i] && !pkt_trig;
      m_ovf[i]  = cap && m_val[i] && !rd_i;
      m_miss[i] = miss;
      if (rd_i) m_rd = old[i];
      if (cap) m_store[i] = time_in;
      m_val[i] = cap ? 1'b1 : (rd_i ? 1'b0 : m_val[i]);
      m_arm[i] = (m_arm[i] && !pkt_done) || req_i;
    end
  endtask

  task automatic drive(bit rv, int rs, bit pd, bit pt, bit re, int rsl);
    req_valid = rv; req_slot = IW'(rs);
    pkt_done = pd; pkt_trig = pt;
    rd_en = re; rd_slot = IW'(rsl);
    time_in = {$urandom, $urandom};
  endtask

  task automatic compare(string tag);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_val[i];
    chk(tag, "slot_valid", W'(slot_valid), W'(v));
    chk(tag, "missed_pulse", W'(missed_pulse), W'(m_miss));
    chk(tag, "ovf_pulse", W'(ovf_pulse), W'(m_ovf));
    chk(tag, "rd_data", rd_data, m_rd);
  endtask

  task automatic cycle(string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic idle(string tag);
    drive(0, 0, 0, 0, 0, 0);
    cycle(tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    rst = 1'b0;
    idle("R1");

    // R2: arm slot 0, triggered packet captures
    drive(1, 0, 0, 0, 0, 0); cycle("R2");
    drive(0, 0, 1, 1, 0, 0); cycle("R2");
    // R5: read slot 0 returns value and clears flag
    drive(0, 0, 0, 0, 1, 0); cycle("R5");
    drive(0, 0, 0, 0, 1, 3); cycle("R5");
    // R3: untriggered packet gives missed, then arming is gone
    drive(1, 1, 0, 0, 0, 0); cycle("R3");
    drive(0, 0, 1, 0, 0, 0); cycle("R3");
    drive(0, 0, 1, 1, 0, 0); cycle("R3");
    idle("R10");
    // R4: second capture on unread slot overflows
    drive(1, 2, 0, 0, 0, 0); cycle("R4");
    drive(0, 0, 1, 1, 0, 0); cycle("R4");
    drive(1, 2, 0, 0, 0, 0); cycle("R4");
    drive(0, 0, 1, 1, 0, 0); cycle("R4");
    idle("R10");
    drive(0, 0, 0, 0, 1, 2); cycle("R4");
    // R6: read and capture same cycle on slot 0
    drive(1, 0, 0, 0, 0, 0); cycle("R6");
    drive(0, 0, 1, 1, 0, 0); cycle("R6");
    drive(1, 0, 0, 0, 0, 0); cycle("R6");
    drive(0, 0, 1, 1, 1, 0); cycle("R6");
    drive(0, 0, 0, 0, 1, 0); cycle("R6");
    // R7: completion with nothing armed
    drive(0, 0, 1, 1, 0, 0); cycle("R7");
    drive(0, 0, 1, 0, 0, 0); cycle("R7");
    // R8: out-of-range request arms nothing
    drive(1, 3, 0, 0, 0, 0); cycle("R8");
    drive(0, 0, 1, 1, 0, 0); cycle("R8");
    drive(0, 0, 1, 0, 0, 0); cycle("R8");
    // R9: request in the completing cycle applies to the next packet
    drive(1, 1, 1, 1, 0, 0); cycle("R9");
    drive(0, 0, 1, 1, 0, 0); cycle("R9");
    drive(0, 0, 0, 0, 1, 1); cycle("R9");
    // R11: all slots resolve on one completion
    drive(1, 0, 0, 0, 0, 0); cycle("R11");
    drive(1, 1, 0, 0, 0, 0); cycle("R11");
    drive(1, 2, 0, 0, 0, 0); cycle("R11");
    drive(0, 0, 1, 1, 0, 0); cycle("R11");
    for (int i = 0; i < N; i++) begin
      drive(0, 0, 0, 0, 1, i); cycle("R11");
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 3) == 0, $urandom % 4,
            ($urandom % 4) == 0, ($urandom % 4) != 0,
            ($urandom % 3) == 0, $urandom % 4);
      cycle("R11");
    end
    idle("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule